// File: doc/BRIEF.md
# Interrupt and Sleep Wake-up Controller

This block collects seven interrupt sources for a small 8-bit controller core and turns them into one vectored request. Three sources are single-cycle timeout pulses from on-chip counters. Three are external pins that trigger on a falling edge. The last is an infrared receive pin whose trigger edge software selects. Each asynchronous pin passes through a synchronizer and an edge detector. Every qualifying event latches a pending flag, whether or not its source is enabled.

Software gates the sources with two enable registers. A global enable is set by an enable strobe or a return-from-interrupt strobe, and it is cleared automatically in the same edge that the vector request is issued. This rules out nested entry. The vector address is fixed at 8 on program page 0.

A sleep strobe parks the core. Any enabled pending flag wakes it. If the global enable is set, the vector request follows on the next cycle. If it is clear, the core simply resumes after the sleep instruction and the flag stays pending.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the flags, enable mask, global enable, sleep state, `wake_o` and `vec_req_o` are all 0, and `vec_addr_o` equals 8.
- R2: A high level on `tmo_i[k]` at a clock edge sets flag bit k (k = 0..2), and the flag is visible after that same edge.
- R3: A falling edge on `ext_pin_i[k]` sets flag bit 4+k. The flag is visible after the third rising clock edge following the pin change. A rising edge sets nothing.
- R4: `ir_pin_i` sets flag bit 3 with the same latency as R3. It triggers on a rising edge when `ir_rise_sel_i` is 1 and on a falling edge when it is 0.
- R5: A flag is set even when its source is disabled. A flag whose mask bit is 0 never causes a request or a wake-up.
- R6: A flag write clears every flag whose data bit is 0 and keeps every flag whose data bit is 1. A source event in the same cycle as a clearing write leaves that flag set.
- R7: Enable write A stores data bits 6..3 into mask bits 6..3. Enable write B stores data bits 2..0 into mask bits 2..0. All other data bits are ignored.
- R8: When the core is awake, the global enable is 1 and an enabled flag is pending, `vec_req_o` pulses for exactly one cycle after the next edge. The global enable drops in that same edge. Several pending flags still produce a single pulse.
- R9: While the global enable is 0, no request is issued. `eni_i` or `reti_i` sets it again, and a request for a still-pending flag follows one cycle later.
- R10: `sleep_i` sets `asleep_o` after the next edge. While the core is asleep, an enabled pending flag makes `wake_o` pulse and clears `asleep_o` after the next edge. If the global enable is 1, `vec_req_o` pulses one cycle after that.
- R11: A wake-up with the global enable at 0 issues no request and leaves the flag set.
- R12: While the core is asleep with no enabled flag pending, it stays asleep and `wake_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_i | input | 3 | Counter timeout pulses |
| ext_pin_i | input | 3 | External interrupt pins, falling-edge triggered |
| ir_pin_i | input | 1 | Infrared receive pin |
| ir_rise_sel_i | input | 1 | 1 selects rising edge for the infrared pin, 0 selects falling edge |
| en_a_wr_i | input | 1 | Write strobe for enable register A |
| en_a_wdata_i | input | 8 | Data for enable register A (bits 6..3 used) |
| en_b_wr_i | input | 1 | Write strobe for enable register B |
| en_b_wdata_i | input | 8 | Data for enable register B (bits 2..0 used) |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 7 | Flag write data; a 0 clears the flag |
| eni_i | input | 1 | Global enable strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| sleep_i | input | 1 | Sleep strobe |
| flags_o | output | 7 | Pending flags |
| en_mask_o | output | 7 | Combined enable mask |
| gie_o | output | 1 | Global enable state |
| asleep_o | output | 1 | Core held in sleep |
| wake_o | output | 1 | One-cycle wake-up pulse |
| vec_req_o | output | 1 | One-cycle vector request |
| vec_addr_o | output | 10 | Vector address (8, page 0) |

## Verification
Each result has a fixed latency. A timeout flag appears one edge after its pulse. A pin flag needs three edges: two synchronizer stages, then the flag register. A request comes one edge after the flag is pending. A wake-up comes one edge after the flag is pending while asleep, and the request follows one edge after the wake-up. Inputs change only on the falling clock edge, and each directed task samples outputs on a falling edge at exactly these counts. It also checks the cycle before the due edge, so that an early result is caught as well as a late one.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
   localparam int N_TMO   = 3;
   localparam int N_EXT   = 3;
   localparam int N_SRC   = N_TMO + 1 + N_EXT;
   localparam int TMO_LSB = 0;
   localparam int IR_BIT  = N_TMO;
   localparam int EXT_LSB = IR_BIT + 1;
   localparam int REG_W   = 8;
   typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int STAGES   = 2,
   parameter bit PROG_POL = 1'b0,
   parameter bit RST_LVL  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic rise_sel_i,
   output logic edge_o
);
   // sh_q[STAGES-1] is the synchronized sample; sh_q[STAGES] is the one before it
   logic [STAGES:0] sh_q;
   logic cur, prev;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {(STAGES+1){RST_LVL}};
      else         sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign cur  = sh_q[STAGES-1];
   assign prev = sh_q[STAGES];

   generate
      if (PROG_POL) begin : g_prog
         assign edge_o = rise_sel_i ? (cur & ~prev) : (prev & ~cur);
      end else begin : g_fall
         logic unused_sel;
         assign unused_sel = rise_sel_i;
         assign edge_o = prev & ~cur;
         // R3: a falling-edge event lasts one cycle
         p_fall_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            edge_o |=> !edge_o);
      end
   endgenerate
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
   import irq_wake_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  src_vec_t         set_i,
   input  logic             en_a_wr_i,
   input  logic [REG_W-1:0] en_a_wdata_i,
   input  logic             en_b_wr_i,
   input  logic [REG_W-1:0] en_b_wdata_i,
   input  logic             flag_wr_i,
   input  src_vec_t         flag_wdata_i,
   output src_vec_t         flags_o,
   output src_vec_t         mask_o
);
   localparam int A_W = N_SRC - IR_BIT;
   logic [A_W-1:0]   en_a_q;
   logic [N_TMO-1:0] en_b_q;
   src_vec_t         flags_q;
   logic             unused_wdata;

   assign unused_wdata = ^{en_a_wdata_i[REG_W-1:N_SRC], en_a_wdata_i[IR_BIT-1:0],
                           en_b_wdata_i[REG_W-1:N_TMO]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_a_q <= '0;
         en_b_q <= '0;
      end else begin
         if (en_a_wr_i) en_a_q <= en_a_wdata_i[N_SRC-1:IR_BIT];
         if (en_b_wr_i) en_b_q <= en_b_wdata_i[N_TMO-1:0];
      end
   end

   // set has priority over a clearing write
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (flag_wr_i ? (flags_q & flag_wdata_i) : flags_q) | set_i;
   end

   assign flags_o = flags_q;
   assign mask_o  = {en_a_q, en_b_q};

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_chk
         // R2: an event always lands in its flag
         p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> flags_o[i]);
         // R6: clearing write without a coincident event removes the flag
         p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_wr_i && !flag_wdata_i[i] && !set_i[i]) |=> !flags_o[i]);
      end
   endgenerate
endmodule

// File: rtl/irq_wake_seq.sv
module irq_wake_seq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pend_i,
   input  logic eni_i,
   input  logic reti_i,
   input  logic sleep_i,
   output logic gie_o,
   output logic asleep_o,
   output logic wake_o,
   output logic vec_req_o
);
   logic gie_q, asleep_q, wake_q, vec_q, take;

   assign take = gie_q & ~asleep_q & pend_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q    <= 1'b0;
         asleep_q <= 1'b0;
         wake_q   <= 1'b0;
         vec_q    <= 1'b0;
      end else begin
         wake_q <= asleep_q & pend_i;
         vec_q  <= take;
         if (asleep_q & pend_i)   asleep_q <= 1'b0;
         else if (sleep_i & ~take) asleep_q <= 1'b1;
         if (take)                 gie_q <= 1'b0;
         else if (eni_i | reti_i)  gie_q <= 1'b1;
      end
   end

   assign gie_o     = gie_q;
   assign asleep_o  = asleep_q;
   assign wake_o    = wake_q;
   assign vec_req_o = vec_q;

   // R8: request is a single-cycle pulse
   p_vec_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_req_o |=> !vec_req_o);
   // R8: entry drops the global enable
   p_vec_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_req_o |-> !gie_o);
   // R10: wake-up leaves sleep
   p_wake_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (!asleep_o && $past(asleep_o)));
   // R10: no request is issued while asleep
   p_no_vec_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      asleep_o |-> !vec_req_o);
   // R12: sleep holds without an enabled pending flag
   p_sleep_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (asleep_o && !pend_i) |=> asleep_o);
   // R9: no request without the global enable
   p_gie_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gie_o) |=> !vec_req_o);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
   import irq_wake_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PC_W        = 10,
   parameter int VEC_ADDR    = 8,
   parameter bit PIN_RST_LVL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_TMO-1:0] tmo_i,
   input  logic [N_EXT-1:0] ext_pin_i,
   input  logic             ir_pin_i,
   input  logic             ir_rise_sel_i,
   input  logic             en_a_wr_i,
   input  logic [REG_W-1:0] en_a_wdata_i,
   input  logic             en_b_wr_i,
   input  logic [REG_W-1:0] en_b_wdata_i,
   input  logic             flag_wr_i,
   input  logic [N_SRC-1:0] flag_wdata_i,
   input  logic             eni_i,
   input  logic             reti_i,
   input  logic             sleep_i,
   output logic [N_SRC-1:0] flags_o,
   output logic [N_SRC-1:0] en_mask_o,
   output logic             gie_o,
   output logic             asleep_o,
   output logic             wake_o,
   output logic             vec_req_o,
   output logic [PC_W-1:0]  vec_addr_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
      $error("VEC_ADDR does not fit in PC_W bits");
   end

   logic [N_EXT-1:0] ext_edge;
   logic             ir_edge;
   src_vec_t         set_vec, flags, mask;
   logic             pend;

   generate
      for (genvar k = 0; k < N_EXT; k++) begin : g_ext
         irq_edge_det #(.STAGES(SYNC_STAGES), .PROG_POL(1'b0), .RST_LVL(PIN_RST_LVL)) i_det (
            .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_pin_i[k]),
            .rise_sel_i(1'b0), .edge_o(ext_edge[k]));
      end
   endgenerate

   irq_edge_det #(.STAGES(SYNC_STAGES), .PROG_POL(1'b1), .RST_LVL(PIN_RST_LVL)) i_ir_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ir_pin_i),
      .rise_sel_i(ir_rise_sel_i), .edge_o(ir_edge));

   assign set_vec = {ext_edge, ir_edge, tmo_i};

   irq_src_regs i_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
      .en_a_wr_i(en_a_wr_i), .en_a_wdata_i(en_a_wdata_i),
      .en_b_wr_i(en_b_wr_i), .en_b_wdata_i(en_b_wdata_i),
      .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
      .flags_o(flags), .mask_o(mask));

   assign pend = |(flags & mask);

   irq_wake_seq i_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend),
      .eni_i(eni_i), .reti_i(reti_i), .sleep_i(sleep_i),
      .gie_o(gie_o), .asleep_o(asleep_o), .wake_o(wake_o), .vec_req_o(vec_req_o));

   assign flags_o    = flags;
   assign en_mask_o  = mask;
   assign vec_addr_o = PC_W'(VEC_ADDR);

   // R5: a request needs an enabled pending flag in the cycle before
   p_req_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_req_o |-> $past(|(flags_o & en_mask_o)));
endmodule

// File: tb/test_irq_wake_ctrl.sv
module test_irq_wake_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tmo = '0;
   logic [2:0] ext = 3'b111;
   logic       ir = 1'b1;
   logic       ir_sel = 1'b0;
   logic       ea_wr = 1'b0, eb_wr = 1'b0, f_wr = 1'b0;
   logic [7:0] ea_d = '0, eb_d = '0;
   logic [6:0] f_d = '0;
   logic       eni = 1'b0, reti = 1'b0, slp = 1'b0;
   logic [6:0] flags, mask;
   logic       gie, asleep, wake, vreq;
   logic [9:0] vaddr;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_wake_ctrl i_irq_wake_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .tmo_i(tmo), .ext_pin_i(ext), .ir_pin_i(ir),
      .ir_rise_sel_i(ir_sel), .en_a_wr_i(ea_wr), .en_a_wdata_i(ea_d),
      .en_b_wr_i(eb_wr), .en_b_wdata_i(eb_d), .flag_wr_i(f_wr), .flag_wdata_i(f_d),
      .eni_i(eni), .reti_i(reti), .sleep_i(slp), .flags_o(flags), .en_mask_o(mask),
      .gie_o(gie), .asleep_o(asleep), .wake_o(wake), .vec_req_o(vreq), .vec_addr_o(vaddr));

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_flags();
      f_wr = 1'b1; f_d = 7'h00; tick(); f_wr = 1'b0;
   endtask

   task automatic wr_en(bit a, logic [7:0] d);
      if (a) begin ea_wr = 1'b1; ea_d = d; end else begin eb_wr = 1'b1; eb_d = d; end
      tick(); ea_wr = 1'b0; eb_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "flags", flags, 0); chk("R1", "mask", mask, 0);
      chk("R1", "gie", gie, 0);     chk("R1", "asleep", asleep, 0);
      chk("R1", "wake", wake, 0);   chk("R1", "vreq", vreq, 0);
      chk("R1", "vaddr", vaddr, 8);
   endtask

   task automatic t_timeout();
      tmo = 3'b010; tick(); tmo = '0;
      chk("R2", "tmo1 flag", flags, 7'h02);
      chk("R5", "no req while disabled", vreq, 0);
      clr_flags(); chk("R6", "clear by zero", flags, 0);
      tmo = 3'b101; tick(); tmo = '0;
      f_wr = 1'b1; f_d = 7'h7F; tick(); f_wr = 1'b0;
      chk("R6", "write one keeps", flags, 7'h05);
      tmo = 3'b001; f_wr = 1'b1; f_d = 7'h00; tick(); tmo = '0; f_wr = 1'b0;
      chk("R6", "set beats clear", flags, 7'h01);
      clr_flags();
   endtask

   task automatic t_ext();
      ext[1] = 1'b0; tick(2);
      chk("R3", "fall not yet", flags, 0);
      tick(); chk("R3", "fall flag", flags, 7'h20);
      clr_flags();
      ext[1] = 1'b1; tick(4);
      chk("R3", "rise ignored", flags, 0);
      ext[2] = 1'b0; tick(3); ext[2] = 1'b1;
      chk("R3", "pin2 fall", flags, 7'h40);
      tick(3); clr_flags();
   endtask

   task automatic t_ir();
      ir_sel = 1'b0; ir = 1'b0; tick(2);
      chk("R4", "ir fall early", flags, 0);
      tick(); chk("R4", "ir fall sel0", flags, 7'h08);
      clr_flags();
      ir_sel = 1'b1; tick(); ir = 1'b1; tick(3);
      chk("R4", "ir rise sel1", flags, 7'h08);
      clr_flags();
      ir = 1'b0; tick(4);
      chk("R4", "ir fall ignored sel1", flags, 0);
      ir = 1'b1; tick(3);
      chk("R4", "ir rise again", flags, 7'h08);
      clr_flags();
   endtask

   task automatic t_enables();
      wr_en(1, 8'h87); chk("R7", "A unused bits", mask, 0);
      wr_en(1, 8'h78); chk("R7", "A bits 6..3", mask, 7'h78);
      wr_en(0, 8'hF8); chk("R7", "B unused bits", mask, 7'h78);
      wr_en(0, 8'h07); chk("R7", "B bits 2..0", mask, 7'h7F);
      wr_en(1, 8'h00); wr_en(0, 8'h00);
      chk("R7", "cleared", mask, 0);
   endtask

   task automatic t_disabled();
      eni = 1'b1; tick(); eni = 1'b0;
      chk("R9", "eni sets gie", gie, 1);
      wr_en(0, 8'h03);
      tmo = 3'b100; tick(); tmo = '0;
      chk("R5", "flag of disabled src", flags, 7'h04);
      for (int i = 0; i < 3; i++) begin
         tick(); chk("R5", "no req from disabled", vreq, 0);
      end
      chk("R5", "gie kept", gie, 1);
      clr_flags();
   endtask

   task automatic t_vector();
      tmo = 3'b011; tick(); tmo = '0;
      chk("R8", "req not before edge", vreq, 0);
      tick();
      chk("R8", "req pulse", vreq, 1); chk("R8", "gie cleared", gie, 0);
      chk("R8", "vector 8", vaddr, 8);
      tick(); chk("R8", "single pulse", vreq, 0);
      tick(2); chk("R9", "no req gie off", vreq, 0);
      reti = 1'b1; tick(); reti = 1'b0;
      chk("R9", "reti sets gie", gie, 1); chk("R9", "req one later", vreq, 0);
      tick(); chk("R9", "req after reti", vreq, 1);
      clr_flags();
      eni = 1'b1; tick(); eni = 1'b0;
      tick(); chk("R9", "no req none pending", vreq, 0);
   endtask

   task automatic t_sleep_gie();
      slp = 1'b1; tick(); slp = 1'b0;
      chk("R10", "asleep", asleep, 1);
      tick(2); chk("R12", "stays asleep", asleep, 1); chk("R12", "no wake", wake, 0);
      tmo = 3'b100; tick(); tmo = '0;
      tick(2); chk("R12", "disabled src no wake", asleep, 1);
      chk("R12", "disabled no wake pulse", wake, 0);
      clr_flags();
      tmo = 3'b001; tick(); tmo = '0;
      chk("R10", "still asleep", asleep, 1); chk("R10", "wake not yet", wake, 0);
      tick(); chk("R10", "wake pulse", wake, 1); chk("R10", "awake", asleep, 0);
      chk("R10", "no req during wake", vreq, 0);
      tick(); chk("R10", "req after wake", vreq, 1); chk("R10", "wake ends", wake, 0);
      clr_flags();
      reti = 1'b1; tick(); reti = 1'b0;
   endtask

   task automatic t_sleep_nogie();
      tmo = 3'b001; tick(2); tmo = '0;
      chk("R8", "gie dropped", gie, 0);
      clr_flags(); tick();
      slp = 1'b1; tick(); slp = 1'b0;
      tmo = 3'b010; tick(); tmo = '0;
      tick(); chk("R11", "wake", wake, 1); chk("R11", "awake", asleep, 0);
      tick(); chk("R11", "no req", vreq, 0);
      tick(); chk("R11", "still no req", vreq, 0);
      chk("R11", "flag kept", flags, 7'h02);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3); t_reset();
      rst_n = 1'b1; tick();
      t_reset();
      t_timeout();
      t_ext();
      t_ir();
      t_enables();
      t_disabled();
      t_vector();
      t_sleep_gie();
      t_sleep_nogie();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule